// File: doc/BRIEF.md
# Mode-Banked Register File with Exception Entry

This block holds the architectural integer state of a small 32-bit RISC core: sixteen visible registers (index 15 being the program counter), a current status word and one saved status word for each exception mode. Every register access is steered through the current processor mode. A register index can therefore land on a private physical copy rather than on the shared one. Instruction decode, the ALU, memory and the ordering of external interrupt sources all sit outside the block.

Each cycle the block can accept one register write, one update of the condition flags and one branch-exchange request. It also takes request strobes for six exception causes: normal interrupt, fast interrupt, supervisor call, prefetch abort, data abort and undefined instruction. When an exception is accepted, the link register of the target mode, the saved status of that mode, the mode field, the interrupt mask bits and the program counter all change on the same clock edge. A branch-exchange request loads the program counter from a register and selects the compressed-instruction state from bit 0 of that register.

Top module: `mode_banked_regs`

## Requirements
- R1: A synchronous active-high reset gives user mode (status word 0x00000010), all flags and the I, F and T bits zero, a program counter of 0, all registers 0, both read outputs 0 and a saved status of 0.
- R2: Each read port returns the register chosen by its index, resolved in the current mode, one clock after the index is presented. The value shown is the one before any update on that same edge. Index 15 returns the program counter.
- R3: A write lands in the physical copy selected by the current mode. User and system modes share one set. Fast-interrupt mode has private copies of indices 8 to 14. Normal-interrupt, supervisor, abort and undefined modes each have private copies of indices 13 and 14 only.
- R4: The status word holds N, Z, C, V in bits 31..28, I in bit 7, F in bit 6, T in bit 5 and the mode in bits 4..0. Bits 27..8 read as zero. A flag write loads bits 31..28 from the 4-bit flag input, with N as its most significant bit.
- R5: On exception entry, the old program counter goes into index 14 of the target mode, the old status word goes into the target mode's saved status, the mode field takes the target code and the program counter takes the vector. Modes and vectors: undefined 5'b11011 at 0x04; supervisor call 5'b10011 at 0x08; prefetch abort 5'b10111 at 0x0C; data abort 5'b10111 at 0x10; normal interrupt 5'b10010 at 0x18; fast interrupt 5'b10001 at 0x1C. User mode is 5'b10000 and system mode is 5'b11111.
- R6: Every exception entry sets I and clears T. Fast-interrupt entry also sets F. Other entries leave F unchanged.
- R7: A branch-exchange request takes the register named by read port A's index. Bit 0 of that register goes to T, and the program counter takes the register value with bit 0 cleared. This request takes precedence over a write to index 15 in the same cycle.
- R8: When several requests arrive together, only one is taken, in this order: data abort, fast interrupt, normal interrupt, prefetch abort, undefined, supervisor call.
- R9: A normal-interrupt request is ignored while I is 1. A fast-interrupt request is ignored while F is 1.
- R10: In a cycle where an exception is taken, the register write, the flag write and the branch-exchange request of that cycle have no effect.
- R11: The saved-status output shows the saved status of the current mode. It is zero in user and system modes.
- R12: Outside exception and branch-exchange cycles, a write to index 15 loads the program counter with the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Read port A register index (also the branch-exchange source) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_a_data | output | 32 | Registered read data, port A |
| rd_b_data | output | 32 | Registered read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| flag_we | input | 1 | Condition flag write enable |
| flag_nzcv | input | 4 | New N, Z, C, V flags |
| irq_req | input | 1 | Normal interrupt request |
| fiq_req | input | 1 | Fast interrupt request |
| swi_req | input | 1 | Supervisor call request |
| pabt_req | input | 1 | Prefetch abort request |
| dabt_req | input | 1 | Data abort request |
| und_req | input | 1 | Undefined instruction request |
| bx_req | input | 1 | Branch-exchange request |
| status_o | output | 32 | Current status word |
| saved_status_o | output | 32 | Saved status of the current mode |
| pc_o | output | 32 | Program counter |

## Verification
Two things can land on one edge and collide. One is a fast and a normal interrupt arriving together. The other is an exception arriving with an ordinary register write and a flag update. The bench raises both interrupt strobes in one cycle, together with a write to index 0 and a flag write of zero. It then judges the outcome from the status word, the program counter and the saved status, and from reading index 0 back to show that the write was dropped. A branch-exchange in the same cycle as a write to the program counter is provoked in the same way, and judged by the program counter and the T bit.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  localparam logic [7:0] VEC_UND  = 8'h04;
  localparam logic [7:0] VEC_SWI  = 8'h08;
  localparam logic [7:0] VEC_PABT = 8'h0C;
  localparam logic [7:0] VEC_DABT = 8'h10;
  localparam logic [7:0] VEC_IRQ  = 8'h18;
  localparam logic [7:0] VEC_FIQ  = 8'h1C;

  // physical layout: 0..14 shared, 15..21 fast bank 8..14,
  // then pairs of (13,14) for irq, svc, abt, und
  localparam int NUM_PHYS  = 30;
  localparam int PHYS_W    = $clog2(NUM_PHYS);
  localparam int NUM_SAVED = 5;
  localparam int SLOT_W    = $clog2(NUM_SAVED);

  function automatic logic [PHYS_W-1:0] phys_sel(input logic [4:0] mode,
                                                 input logic [3:0] idx);
    logic [PHYS_W-1:0] base;
    base = {1'b0, idx};
    phys_sel = base;
    if (mode == MODE_FIQ && idx >= 4'd8 && idx <= 4'd14)
      phys_sel = base + 5'd7;
    else if (idx == 4'd13 || idx == 4'd14) begin
      case (mode)
        MODE_IRQ: phys_sel = base + 5'd9;
        MODE_SVC: phys_sel = base + 5'd11;
        MODE_ABT: phys_sel = base + 5'd13;
        MODE_UND: phys_sel = base + 5'd15;
        default:  phys_sel = base;
      endcase
    end
  endfunction

  function automatic logic [SLOT_W-1:0] saved_slot(input logic [4:0] mode);
    case (mode)
      MODE_FIQ: saved_slot = 3'd0;
      MODE_IRQ: saved_slot = 3'd1;
      MODE_SVC: saved_slot = 3'd2;
      MODE_ABT: saved_slot = 3'd3;
      default:  saved_slot = 3'd4;
    endcase
  endfunction

  function automatic logic has_saved(input logic [4:0] mode);
    has_saved = !(mode == MODE_USR || mode == MODE_SYS);
  endfunction

endpackage

// File: rtl/mrf_exc_sel.sv
module mrf_exc_sel
  import mrf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_req,
  input  logic       fiq_req,
  input  logic       swi_req,
  input  logic       pabt_req,
  input  logic       dabt_req,
  input  logic       und_req,
  input  logic       i_mask,
  input  logic       f_mask,
  output logic       take,
  output logic [4:0] tgt_mode,
  output logic [7:0] vec,
  output logic       set_f
);

  logic irq_live, fiq_live;
  assign irq_live = irq_req && !i_mask;
  assign fiq_live = fiq_req && !f_mask;

  always_comb begin
    take     = 1'b1;
    tgt_mode = MODE_USR;
    vec      = 8'h00;
    set_f    = 1'b0;
    if (dabt_req) begin
      tgt_mode = MODE_ABT; vec = VEC_DABT;
    end else if (fiq_live) begin
      tgt_mode = MODE_FIQ; vec = VEC_FIQ; set_f = 1'b1;
    end else if (irq_live) begin
      tgt_mode = MODE_IRQ; vec = VEC_IRQ;
    end else if (pabt_req) begin
      tgt_mode = MODE_ABT; vec = VEC_PABT;
    end else if (und_req) begin
      tgt_mode = MODE_UND; vec = VEC_UND;
    end else if (swi_req) begin
      tgt_mode = MODE_SVC; vec = VEC_SWI;
    end else begin
      take = 1'b0;
    end
  end

  // R8: fast interrupt beats a simultaneous normal interrupt
  p_fiq_over_irq_r8: assert property (@(posedge clk) disable iff (rst)
    (fiq_req && !f_mask && irq_req && !dabt_req) |-> (take && tgt_mode == MODE_FIQ));

  // R9: a masked normal interrupt never selects its mode by itself
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (i_mask && !fiq_live && !dabt_req && !pabt_req && !und_req && !swi_req) |-> !take);

endmodule

// File: rtl/mrf_phys_file.sv
module mrf_phys_file
  import mrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_gen,
  input  logic [PHYS_W-1:0] wa_gen,
  input  logic [DATA_W-1:0] wd_gen,
  input  logic              we_lnk,
  input  logic [PHYS_W-1:0] wa_lnk,
  input  logic [DATA_W-1:0] wd_lnk,
  input  logic [PHYS_W-1:0] ra_a,
  input  logic [PHYS_W-1:0] ra_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);

  localparam int DEPTH = 2 ** PHYS_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      if (we_gen) mem[wa_gen] <= wd_gen;
      if (we_lnk) mem[wa_lnk] <= wd_lnk;
    end
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];

  // R10: exception link write never meets a general write
  p_ports_disjoint_r10: assert property (@(posedge clk) disable iff (rst)
    !(we_gen && we_lnk));

endmodule

// File: rtl/mode_banked_regs.sv
module mode_banked_regs
  import mrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rd_a_idx,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag_we,
  input  logic [3:0]        flag_nzcv,
  input  logic              irq_req,
  input  logic              fiq_req,
  input  logic              swi_req,
  input  logic              pabt_req,
  input  logic              dabt_req,
  input  logic              und_req,
  input  logic              bx_req,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] saved_status_o,
  output logic [DATA_W-1:0] pc_o
);

  localparam logic [3:0] PC_IDX = 4'd15;
  localparam int PAD_W = DATA_W - 12;

  logic [3:0]        flags_q;
  logic              i_q, f_q, t_q;
  logic [4:0]        mode_q;
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] saved_q [NUM_SAVED];

  logic              exc_take, exc_set_f;
  logic [4:0]        exc_mode;
  logic [7:0]        exc_vec;
  logic [DATA_W-1:0] file_a, file_b, val_a, val_b;
  logic              bx_take, wr_take, wr_gen;

  assign status_o = {flags_q, {PAD_W{1'b0}}, i_q, f_q, t_q, mode_q};
  assign pc_o     = pc_q;
  assign saved_status_o = has_saved(mode_q) ? saved_q[saved_slot(mode_q)] : '0;

  mrf_exc_sel u_sel (
    .clk(clk), .rst(rst),
    .irq_req(irq_req), .fiq_req(fiq_req), .swi_req(swi_req),
    .pabt_req(pabt_req), .dabt_req(dabt_req), .und_req(und_req),
    .i_mask(i_q), .f_mask(f_q),
    .take(exc_take), .tgt_mode(exc_mode), .vec(exc_vec), .set_f(exc_set_f)
  );

  assign bx_take = bx_req && !exc_take;
  assign wr_take = wr_en && !exc_take;
  assign wr_gen  = wr_take && (wr_idx != PC_IDX);

  mrf_phys_file #(.DATA_W(DATA_W)) u_file (
    .clk(clk), .rst(rst),
    .we_gen(wr_gen), .wa_gen(phys_sel(mode_q, wr_idx)), .wd_gen(wr_data),
    .we_lnk(exc_take), .wa_lnk(phys_sel(exc_mode, 4'd14)), .wd_lnk(pc_q),
    .ra_a(phys_sel(mode_q, rd_a_idx)), .ra_b(phys_sel(mode_q, rd_b_idx)),
    .rd_a(file_a), .rd_b(file_b)
  );

  assign val_a = (rd_a_idx == PC_IDX) ? pc_q : file_a;
  assign val_b = (rd_b_idx == PC_IDX) ? pc_q : file_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a_data <= '0;
      rd_b_data <= '0;
      flags_q   <= '0;
      i_q       <= 1'b0;
      f_q       <= 1'b0;
      t_q       <= 1'b0;
      mode_q    <= MODE_USR;
      pc_q      <= '0;
      for (int k = 0; k < NUM_SAVED; k++) saved_q[k] <= '0;
    end else begin
      rd_a_data <= val_a;
      rd_b_data <= val_b;
      if (exc_take) begin
        saved_q[saved_slot(exc_mode)] <= status_o;
        mode_q <= exc_mode;
        i_q    <= 1'b1;
        t_q    <= 1'b0;
        if (exc_set_f) f_q <= 1'b1;
        pc_q   <= {{(DATA_W-8){1'b0}}, exc_vec};
      end else begin
        if (flag_we) flags_q <= flag_nzcv;
        if (bx_take) begin
          t_q  <= val_a[0];
          pc_q <= {val_a[DATA_W-1:1], 1'b0};
        end else if (wr_take && wr_idx == PC_IDX) begin
          pc_q <= wr_data;
        end
      end
    end
  end

  // R6: entry masks normal interrupts and leaves the compressed state
  p_entry_masks_r6: assert property (@(posedge clk) disable iff (rst)
    exc_take |=> (status_o[7] && !status_o[5]));

  // R6: fast entry also masks fast interrupts
  p_fiq_sets_f_r6: assert property (@(posedge clk) disable iff (rst)
    (exc_take && exc_set_f) |=> status_o[6]);

  // R5: vectors are word aligned inside the low table
  p_vector_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    exc_take |=> (pc_o[1:0] == 2'b00 && pc_o < 32));

  // R7: branch-exchange target is always halfword aligned
  p_bx_even_r7: assert property (@(posedge clk) disable iff (rst)
    bx_take |=> !pc_o[0]);

  // R4: unused status bits stay zero, mode stays legal
  p_mode_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (status_o[4:0] == MODE_USR || status_o[4:0] == MODE_FIQ ||
     status_o[4:0] == MODE_IRQ || status_o[4:0] == MODE_SVC ||
     status_o[4:0] == MODE_ABT || status_o[4:0] == MODE_UND ||
     status_o[4:0] == MODE_SYS));

endmodule

// File: tb/mode_banked_regs_tb.sv
module mode_banked_regs_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, flag_we;
  logic [3:0]  flag_nzcv;
  logic        irq_req, fiq_req, swi_req, pabt_req, dabt_req, und_req, bx_req;
  logic [31:0] status_o, saved_status_o, pc_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  mode_banked_regs u_dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .flag_we(flag_we), .flag_nzcv(flag_nzcv),
    .irq_req(irq_req), .fiq_req(fiq_req), .swi_req(swi_req),
    .pabt_req(pabt_req), .dabt_req(dabt_req), .und_req(und_req),
    .bx_req(bx_req),
    .status_o(status_o), .saved_status_o(saved_status_o), .pc_o(pc_o)
  );

  // {index, data} pairs for the user bank
  localparam logic [35:0] VEC_TAB [15] = '{
    {4'd0,  32'h0000_0001}, {4'd1,  32'hFFFF_FFFF}, {4'd2,  32'h8000_0000},
    {4'd3,  32'h1234_5678}, {4'd4,  32'hA5A5_5A5A}, {4'd5,  32'h0000_0000},
    {4'd6,  32'h7FFF_FFFF}, {4'd7,  32'hDEAD_BEEF}, {4'd8,  32'h0808_0808},
    {4'd9,  32'h0909_0909}, {4'd10, 32'h1010_1010}, {4'd11, 32'h1111_1111},
    {4'd12, 32'h1212_1212}, {4'd13, 32'h1313_1313}, {4'd14, 32'h1414_1414}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_idx = 0; wr_data = 0; flag_we = 0; flag_nzcv = 0;
    irq_req = 0; fiq_req = 0; swi_req = 0; pabt_req = 0; dabt_req = 0;
    und_req = 0; bx_req = 0;
  endtask

  task automatic do_reset();
    idle();
    rd_a_idx = 0; rd_b_idx = 0;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    wr_en = 1; wr_idx = idx; wr_data = d;
    tick();
  endtask

  task automatic rd_a(input string req, input logic [3:0] idx, input logic [31:0] exp);
    rd_a_idx = idx;
    @(negedge clk);
    chk(req, rd_a_data, exp);
  endtask

  task automatic rd_b(input string req, input logic [3:0] idx, input logic [31:0] exp);
    rd_b_idx = idx;
    @(negedge clk);
    chk(req, rd_b_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status_o, 32'h0000_0010);
    chk("R1 pc", pc_o, 32'h0);
    chk("R1 saved", saved_status_o, 32'h0);
    chk("R1 rd_a", rd_a_data, 32'h0);
    chk("R11 saved in user", saved_status_o, 32'h0);

    // R3 user bank walk from the vector table
    for (int n = 0; n < 15; n++) wr(VEC_TAB[n][35:32], VEC_TAB[n][31:0]);
    for (int n = 0; n < 15; n++) begin
      if (n % 2 == 0) rd_a("R3 user bank A", VEC_TAB[n][35:32], VEC_TAB[n][31:0]);
      else            rd_b("R3 user bank B", VEC_TAB[n][35:32], VEC_TAB[n][31:0]);
    end

    // R12 write to pc, R2 read of index 15
    wr(4'd15, 32'h0000_0100);
    chk("R12 pc write", pc_o, 32'h100);
    rd_a("R2 read pc", 4'd15, 32'h100);

    // R4 flag write
    flag_we = 1; flag_nzcv = 4'b1010; tick();
    chk("R4 flags", status_o, 32'hA000_0010);

    // R8 + R10: fast and normal interrupt with write and flag write
    fiq_req = 1; irq_req = 1; wr_en = 1; wr_idx = 0; wr_data = 32'hDEAD_0000;
    flag_we = 1; flag_nzcv = 4'b0000;
    tick();
    chk("R8 fiq wins status", status_o, 32'hA000_00D1);
    chk("R5 fiq vector", pc_o, 32'h1C);
    chk("R5 saved status", saved_status_o, 32'hA000_0010);
    rd_a("R5 link", 4'd14, 32'h100);
    rd_b("R3 fiq r8 private", 4'd8, 32'h0);
    rd_a("R10 write dropped", 4'd0, 32'h1);
    rd_b("R3 fiq r13 private", 4'd13, 32'h0);

    // R9 masked normal interrupt in fast mode
    wr(4'd8, 32'h88);
    irq_req = 1; tick();
    chk("R9 irq masked status", status_o, 32'hA000_00D1);
    chk("R9 irq masked pc", pc_o, 32'h1C);
    rd_a("R3 fiq r8 write", 4'd8, 32'h88);

    // R5 supervisor call from fast mode
    swi_req = 1; tick();
    chk("R5 svc status", status_o, 32'hA000_00D3);
    chk("R5 svc vector", pc_o, 32'h08);
    chk("R11 svc saved", saved_status_o, 32'hA000_00D1);
    rd_a("R5 svc link", 4'd14, 32'h1C);
    rd_b("R3 svc sees user r8", 4'd8, 32'h0808_0808);
    rd_a("R3 svc r13 private", 4'd13, 32'h0);
    rd_b("R3 svc sees user r12", 4'd12, 32'h1212_1212);

    // R7 branch-exchange into compressed state
    wr(4'd13, 32'h0000_0201);
    bx_req = 1; rd_a_idx = 4'd13; tick();
    chk("R7 bx pc", pc_o, 32'h200);
    chk("R7 bx T", status_o, 32'hA000_00F3);

    // R6 undefined entry clears T
    und_req = 1; tick();
    chk("R6 und status", status_o, 32'hA000_00DB);
    chk("R5 und vector", pc_o, 32'h04);
    chk("R11 und saved", saved_status_o, 32'hA000_00F3);
    rd_a("R5 und link", 4'd14, 32'h200);
    rd_b("R3 und r13 private", 4'd13, 32'h0);
    rd_a("R2 pc read", 4'd15, 32'h04);

    // R8 data abort over fast and normal interrupt
    do_reset();
    dabt_req = 1; fiq_req = 1; irq_req = 1; tick();
    chk("R8 dabt status", status_o, 32'h0000_0097);
    chk("R8 dabt vector", pc_o, 32'h10);

    // R8 prefetch abort over undefined and supervisor call
    do_reset();
    pabt_req = 1; und_req = 1; swi_req = 1; tick();
    chk("R8 pabt vector", pc_o, 32'h0C);
    chk("R8 pabt status", status_o, 32'h0000_0097);

    // R8 undefined over supervisor call
    do_reset();
    und_req = 1; swi_req = 1; tick();
    chk("R8 und vector", pc_o, 32'h04);
    chk("R8 und status", status_o, 32'h0000_009B);

    // R6 normal interrupt leaves F clear; then fast interrupt still taken
    do_reset();
    irq_req = 1; tick();
    chk("R6 irq status", status_o, 32'h0000_0092);
    chk("R5 irq vector", pc_o, 32'h18);
    fiq_req = 1; tick();
    chk("R9 fiq unmasked status", status_o, 32'h0000_00D1);
    chk("R11 fiq saved", saved_status_o, 32'h0000_0092);
    wr(4'd15, 32'h0000_0040);
    fiq_req = 1; tick();
    chk("R9 fiq masked pc", pc_o, 32'h40);
    chk("R9 fiq masked status", status_o, 32'h0000_00D1);

    // R7 branch-exchange beats pc write; even source keeps T clear
    do_reset();
    wr(4'd2, 32'h0000_0301);
    bx_req = 1; rd_a_idx = 4'd2; wr_en = 1; wr_idx = 4'd15; wr_data = 32'h5000;
    tick();
    chk("R7 bx over write pc", pc_o, 32'h300);
    chk("R7 bx T set", status_o, 32'h0000_0030);
    wr(4'd3, 32'h0000_0480);
    bx_req = 1; rd_a_idx = 4'd3; tick();
    chk("R7 bx even pc", pc_o, 32'h480);
    chk("R7 bx T clear", status_o, 32'h0000_0010);

    // R10 exception drops branch-exchange
    bx_req = 1; rd_a_idx = 4'd2; swi_req = 1; tick();
    chk("R10 bx dropped", status_o, 32'h0000_0093);
    chk("R10 bx dropped pc", pc_o, 32'h08);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule